// File: doc/BRIEF.md
# Capability List Payload-Size Extractor

This block searches a device's 256-byte configuration space for the PCI Express capability. It reads the space through a simple synchronous read port: it presents a byte address with a read enable, and the addressed dword comes back on the following cycle. A start pulse begins the walk at the capabilities pointer. The block then follows the linked list of capability headers until it meets capability ID 0x10. From that capability it reads the two dwords that describe the payload limits and reports the supported and currently active maximum payload sizes in bytes.

The walk always ends, whatever the list holds. When it ends, the block raises `done` together with exactly one of `found` or `error`. An empty list, a list that ends without the wanted ID, a pointer into the header region below 0x40 and an over-long or circular list all end in `error`. A field value outside the defined range is reported through its own reserved flag, and its size reads as zero. The results stay on the outputs until the next accepted start.

Top module: `cfg_cap_walker`

## Requirements
- R1: After reset, `busy`, `done`, `found`, `error`, `rd_en`, both reserved flags and both byte sizes are low or zero.
- R2: After an accepted start, the first read goes to the dword at 0x34. The capabilities pointer is taken from byte 0 of that dword (bits 7:0), and its low two bits are cleared before it is used.
- R3: Each capability header holds its ID in bits 7:0 and the next pointer in bits 15:8. The walk reads headers in list order and stops at the first header whose ID is 0x10.
- R4: Every read address has bits 1:0 equal to zero, because every pointer has its low two bits cleared.
- R5: When the capability is found, the block reads the dword at base+4, whose bits 2:0 give the supported field, and the dword at base+8, whose bits 7:5 give the active field. Each size is 1 << (field + 7) bytes; for example, field 5 gives 4096, 3 gives 1024, 2 gives 512 and 0 gives 128. On completion `done` and `found` are high and `error` is low.
- R6: A field value of 6 or 7 sets that field's reserved flag and reports its size as 0, while `found` stays high.
- R7: A next pointer of 0x00 met before ID 0x10 ends the walk with `done` and `error` high, `found` low and both sizes 0.
- R8: A nonzero capabilities pointer or next pointer below 0x40 (after masking) ends the walk with `error`.
- R9: At most 48 headers are read. If the 48th header read is not ID 0x10, the walk ends with `error`. A target found at the 48th header is still reported as found.
- R10: With N headers read, `done` rises 6+2N clock edges after the edge that accepts start on success. On failure it rises 2+2N edges after that edge, with N=0 for a bad capabilities pointer. Results hold until the next accepted start, and a start while `busy` is ignored.
- R11: `busy` is high from the edge that accepts start until the edge that raises `done`, and reads are issued only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| rd_en | output | 1 | Configuration read request |
| rd_addr | output | 8 | Byte address of the requested dword (dword aligned) |
| rd_data | input | 32 | Dword returned one cycle after the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished; results valid |
| found | output | 1 | Capability ID 0x10 was located |
| error | output | 1 | Walk ended without locating the capability |
| cap_bytes | output | 13 | Supported maximum payload in bytes |
| cur_bytes | output | 13 | Active maximum payload in bytes |
| cap_rsvd | output | 1 | Supported field held a reserved code |
| cur_rsvd | output | 1 | Active field held a reserved code |

## Verification
The bench builds the block with its default parameters: a 48-header limit, a 0x40 pointer floor, a start offset of 0x34 and target ID 0x10. With these values a chain that visits every dword from 0x40 to 0xFC can be exactly 48 headers long. This brings the hop limit into reach from both sides: a target found on the last permitted header, and a circular list that reaches the limit and ends in error. Directed lists also cover unaligned pointers, the reserved field codes and both kinds of illegal pointer, and the cycle at which `done` rises is checked in every case.

// File: rtl/cwalk_pkg.sv
package cwalk_pkg;

    localparam int SIZE_W  = 13;
    localparam int FIELD_W = 3;
    localparam int MAX_FIELD = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PTR_REQ,
        S_PTR_WAIT,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_DCAP_REQ,
        S_DCAP_WAIT,
        S_DCTL_REQ,
        S_DCTL_WAIT
    } walk_state_e;

    typedef struct packed {
        logic done;
        logic found;
        logic error;
    } walk_status_t;

    typedef struct packed {
        logic              rsvd;
        logic [SIZE_W-1:0] bytes;
    } mps_t;

    function automatic logic [7:0] align_ptr(input logic [7:0] p);
        return {p[7:2], 2'b00};
    endfunction

    function automatic mps_t decode_mps(input logic [FIELD_W-1:0] f);
        mps_t r;
        if (int'(f) > MAX_FIELD) begin
            r.rsvd  = 1'b1;
            r.bytes = '0;
        end else begin
            r.rsvd  = 1'b0;
            r.bytes = SIZE_W'(1) << (4'(f) + 4'd7);
        end
        return r;
    endfunction

endpackage

// File: rtl/cwalk_fsm.sv
module cwalk_fsm
    import cwalk_pkg::*;
#(
    parameter int         MAX_HOPS  = 48,
    parameter logic [7:0] START_PTR = 8'h34,
    parameter logic [7:0] MIN_PTR   = 8'h40,
    parameter logic [7:0] TARGET_ID = 8'h10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                rd_en,
    output logic [7:0]          rd_addr,
    input  logic [31:0]         rd_data,
    output logic                busy,
    output walk_status_t        status,
    output logic [FIELD_W-1:0]  cap_field,
    output logic [FIELD_W-1:0]  cur_field
);

    localparam int HOP_W = $clog2(MAX_HOPS + 1);
    localparam int LANE  = int'(START_PTR[1:0]);

    walk_state_e      state;
    logic [7:0]       ptr;
    logic [HOP_W-1:0] hops;

    logic [7:0] first_ptr;
    logic [7:0] hdr_id;
    logic [7:0] hdr_next;
    logic       hop_limit;

    assign first_ptr = align_ptr(rd_data[LANE*8 +: 8]);
    assign hdr_id    = rd_data[7:0];
    assign hdr_next  = align_ptr(rd_data[15:8]);
    assign hop_limit = (hops >= HOP_W'(MAX_HOPS));
    assign busy      = (state != S_IDLE);

    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        case (state)
            S_PTR_REQ:  begin rd_en = 1'b1; rd_addr = align_ptr(START_PTR); end
            S_HDR_REQ:  begin rd_en = 1'b1; rd_addr = ptr;                  end
            S_DCAP_REQ: begin rd_en = 1'b1; rd_addr = ptr + 8'd4;           end
            S_DCTL_REQ: begin rd_en = 1'b1; rd_addr = ptr + 8'd8;           end
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ptr       <= '0;
            hops      <= '0;
            status    <= '0;
            cap_field <= '0;
            cur_field <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        status    <= '0;
                        cap_field <= '0;
                        cur_field <= '0;
                        hops      <= '0;
                        state     <= S_PTR_REQ;
                    end
                end
                S_PTR_REQ: state <= S_PTR_WAIT;
                S_PTR_WAIT: begin
                    if (first_ptr < MIN_PTR) begin
                        status <= '{done: 1'b1, found: 1'b0, error: 1'b1};
                        state  <= S_IDLE;
                    end else begin
                        ptr   <= first_ptr;
                        state <= S_HDR_REQ;
                    end
                end
                S_HDR_REQ: begin
                    hops  <= hops + 1'b1;
                    state <= S_HDR_WAIT;
                end
                S_HDR_WAIT: begin
                    if (hdr_id == TARGET_ID) begin
                        state <= S_DCAP_REQ;
                    end else if (hdr_next < MIN_PTR || hop_limit) begin
                        status <= '{done: 1'b1, found: 1'b0, error: 1'b1};
                        state  <= S_IDLE;
                    end else begin
                        ptr   <= hdr_next;
                        state <= S_HDR_REQ;
                    end
                end
                S_DCAP_REQ: state <= S_DCAP_WAIT;
                S_DCAP_WAIT: begin
                    cap_field <= rd_data[2:0];
                    state     <= S_DCTL_REQ;
                end
                S_DCTL_REQ: state <= S_DCTL_WAIT;
                S_DCTL_WAIT: begin
                    cur_field <= rd_data[7:5];
                    status    <= '{done: 1'b1, found: 1'b1, error: 1'b0};
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cwalk_decode.sv
module cwalk_decode
    import cwalk_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic               valid,
    output mps_t               info
);

    always_comb begin
        info = valid ? decode_mps(field) : '0;
    end

endmodule

// File: rtl/cfg_cap_walker.sv
module cfg_cap_walker
    import cwalk_pkg::*;
#(
    parameter int         MAX_HOPS  = 48,
    parameter logic [7:0] START_PTR = 8'h34,
    parameter logic [7:0] MIN_PTR   = 8'h40,
    parameter logic [7:0] TARGET_ID = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_en,
    output logic [7:0]        rd_addr,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              error,
    output logic [SIZE_W-1:0] cap_bytes,
    output logic [SIZE_W-1:0] cur_bytes,
    output logic              cap_rsvd,
    output logic              cur_rsvd
);

    localparam int N_FIELDS = 2;

    walk_status_t       status;
    logic [FIELD_W-1:0] fields [N_FIELDS];
    mps_t               infos  [N_FIELDS];

    cwalk_fsm #(
        .MAX_HOPS  (MAX_HOPS),
        .START_PTR (START_PTR),
        .MIN_PTR   (MIN_PTR),
        .TARGET_ID (TARGET_ID)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .status    (status),
        .cap_field (fields[0]),
        .cur_field (fields[1])
    );

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_dec
        cwalk_decode u_dec (
            .field (fields[i]),
            .valid (status.found),
            .info  (infos[i])
        );
    end

    assign done      = status.done;
    assign found     = status.found;
    assign error     = status.error;
    assign cap_bytes = infos[0].bytes;
    assign cap_rsvd  = infos[0].rsvd;
    assign cur_bytes = infos[1].bytes;
    assign cur_rsvd  = infos[1].rsvd;

endmodule

// File: rtl/cwalk_checker.sv
module cwalk_checker
    import cwalk_pkg::*;
#(
    parameter int         MAX_HOPS  = 48,
    parameter logic [7:0] START_PTR = 8'h34
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              rd_en,
    input logic [7:0]        rd_addr,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              error,
    input logic [SIZE_W-1:0] cap_bytes,
    input logic [SIZE_W-1:0] cur_bytes,
    input logic              cap_rsvd,
    input logic              cur_rsvd
);

    localparam int RD_LIMIT = MAX_HOPS + 3;
    localparam int CNT_W    = $clog2(RD_LIMIT + 2);

    logic [CNT_W-1:0] reads_seen;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) reads_seen <= '0;
        else if (rd_en)              reads_seen <= reads_seen + 1'b1;
    end

    assert_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr[1:0] == 2'b00));

    assert_first_read_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (rd_en && rd_addr == {START_PTR[7:2], 2'b00}));

    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (found != error));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !found |-> (cap_bytes == '0 && cur_bytes == '0 && !cap_rsvd && !cur_rsvd));

    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_rsvd |-> cap_bytes == '0) and (cur_rsvd |-> cur_bytes == '0));

    assert_pow2_R5: assert property (@(posedge clk) disable iff (rst)
        (found && !cap_rsvd) |-> ($countones(cap_bytes) == 1));

    assert_reads_busy_R11: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_hop_bound_R9: assert property (@(posedge clk) disable iff (rst)
        int'(reads_seen) <= RD_LIMIT);

endmodule

bind cfg_cap_walker cwalk_checker #(
    .MAX_HOPS  (MAX_HOPS),
    .START_PTR (START_PTR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .error     (error),
    .cap_bytes (cap_bytes),
    .cur_bytes (cur_bytes),
    .cap_rsvd  (cap_rsvd),
    .cur_rsvd  (cur_rsvd)
);

// File: tb/cfg_cap_walker_bench.sv
`timescale 1ns/1ps
module cfg_cap_walker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic        busy, done, found, error;
    logic [12:0] cap_bytes, cur_bytes;
    logic        cap_rsvd, cur_rsvd;

    logic [31:0] mem [64];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[7:2]];
    end

    cfg_cap_walker u_cfg_cap_walker (
        .clk (clk), .rst (rst), .start (start),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .busy (busy), .done (done), .found (found), .error (error),
        .cap_bytes (cap_bytes), .cur_bytes (cur_bytes),
        .cap_rsvd (cap_rsvd), .cur_rsvd (cur_rsvd)
    );

    function automatic int exp_size(input int f);
        return (f > 5) ? 0 : (1 << (f + 7));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic set_hdr(input int addr, input logic [7:0] id, input logic [7:0] nxt);
        mem[addr >> 2] = {16'h0, nxt, id};
    endtask

    // Starts a walk, returns edges until done; optional stray start at edge 3.
    task automatic run_walk(input bit stray, output int lat, output bit busy_ok);
        lat = 0;
        busy_ok = 1'b1;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) begin
                if (busy) busy_ok = 1'b0;
                break;
            end
            if (!busy) busy_ok = 1'b0;
            start = (stray && lat == 3);
            if (lat > 400) break;
        end
        start = 1'b0;
    endtask

    task automatic expect_found(input string req, input int lat, input int exp_lat,
                                input int fcap, input int fcur);
        check(found && !error && done, req, {found, error}, 2);
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        check(int'(cap_bytes) == exp_size(fcap), {req, " cap size"}, cap_bytes, exp_size(fcap));
        check(int'(cur_bytes) == exp_size(fcur), {req, " cur size"}, cur_bytes, exp_size(fcur));
        check(cap_rsvd == (fcap > 5) && cur_rsvd == (fcur > 5), {req, " rsvd"},
              {cap_rsvd, cur_rsvd}, {(fcap > 5), (fcur > 5)});
    endtask

    task automatic expect_error(input string req, input int lat, input int exp_lat);
        check(error && !found && done, req, {found, error}, 1);
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        check(cap_bytes == 0 && cur_bytes == 0, {req, " sizes zero"}, cap_bytes + cur_bytes, 0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !found && !error && !rd_en, "R1 flags",
              {busy, done, found, error, rd_en}, 0);
        check(cap_bytes == 0 && cur_bytes == 0 && !cap_rsvd && !cur_rsvd, "R1 sizes",
              cap_bytes + cur_bytes, 0);
    endtask

    task automatic t_two_hop();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h01, 8'h50);
        set_hdr(8'h50, 8'h10, 8'h00);
        mem[8'h54 >> 2] = 32'h0000_8fc2;   // field 2
        mem[8'h58 >> 2] = 32'h0000_2810;   // field 0
        run_walk(1'b0, lat, bok);
        expect_found("R3 R5 two-hop", lat, 10, 2, 0);
        check(bok, "R11 busy window", bok, 1);
        repeat (5) @(negedge clk);
        check(done && found && cap_bytes == 13'd512 && cur_bytes == 13'd128,
              "R10 results held", cap_bytes, 512);
    endtask

    task automatic t_unaligned();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'hAABB_CC4B;           // pointer 0x4B -> 0x48
        set_hdr(8'h48, 8'h10, 8'h5F);
        mem[8'h4C >> 2] = 32'h0000_0005;   // field 5
        mem[8'h50 >> 2] = 32'h0000_0060;   // field 3
        run_walk(1'b0, lat, bok);
        expect_found("R2 R4 masked pointer", lat, 8, 5, 3);
    endtask

    task automatic t_reserved();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0060;
        set_hdr(8'h60, 8'h03, 8'h71);      // next 0x71 -> 0x70
        set_hdr(8'h70, 8'h10, 8'h00);
        mem[8'h74 >> 2] = 32'h0000_0006;   // field 6
        mem[8'h78 >> 2] = 32'h0000_00E0;   // field 7
        run_walk(1'b0, lat, bok);
        expect_found("R6 reserved codes", lat, 10, 6, 7);
    endtask

    task automatic t_end_of_list();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h05, 8'h00);
        run_walk(1'b0, lat, bok);
        expect_error("R7 end of list", lat, 4);
        mem[13] = 32'h0000_0000;
        run_walk(1'b0, lat, bok);
        expect_error("R7 empty list", lat, 2);
    endtask

    task automatic t_low_ptr();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0030;
        run_walk(1'b0, lat, bok);
        expect_error("R8 low cap pointer", lat, 2);
        mem[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h05, 8'h3C);
        run_walk(1'b0, lat, bok);
        expect_error("R8 low next pointer", lat, 4);
    endtask

    task automatic t_loop();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h05, 8'h44);
        set_hdr(8'h44, 8'h05, 8'h40);
        run_walk(1'b0, lat, bok);
        expect_error("R9 looped list", lat, 2 + 2 * 48);
    endtask

    task automatic t_last_hop();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0044;
        for (int a = 8'h44; a < 8'hFC; a += 4) set_hdr(a, 8'h01, 8'(a + 4));
        set_hdr(8'hFC, 8'h01, 8'h40);
        set_hdr(8'h40, 8'h10, 8'h00);
        set_hdr(8'h44, 8'h05, 8'h48);      // also supported field 5
        set_hdr(8'h48, 8'h60, 8'h4C);      // also active field 3
        run_walk(1'b0, lat, bok);
        expect_found("R9 target on 48th header", lat, 6 + 2 * 48, 5, 3);
    endtask

    task automatic t_stray_start();
        int lat; bit bok;
        clear_mem();
        mem[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h01, 8'h50);
        set_hdr(8'h50, 8'h10, 8'h00);
        mem[8'h54 >> 2] = 32'h0000_0001;
        mem[8'h58 >> 2] = 32'h0000_0040;
        run_walk(1'b1, lat, bok);
        expect_found("R10 start while busy", lat, 10, 1, 2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_two_hop();
        t_unaligned();
        t_reserved();
        t_end_of_list();
        t_low_ptr();
        t_loop();
        t_last_hop();
        t_stray_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule